// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer of a 10-bit charge-redistribution converter. A single-cycle start request launches one conversion. The conversion has a fixed sampling window in which the sample switches are closed. A binary search follows, deciding one bit per clock from the most significant bit down. Each trial code is driven to the switch array, and one comparator bit comes back per step. The finished code is presented together with a one-cycle completion flag.

The comparator input is active-high for "summing node above the trip point", and a high value clears the bit under test. Each bit is also sent out on a one-bit stream as soon as it is decided, so a serial port can shift the code out while the search is still running. The machine has four states. ST_IDLE moves to ST_SAMPLE on an accepted start. ST_SAMPLE moves to ST_CONVERT when the sampling count expires. ST_CONVERT moves to ST_DONE after the least significant decision. ST_DONE moves to ST_SAMPLE if a start arrives in that cycle, and to ST_IDLE otherwise. A start is accepted only in ST_IDLE and ST_DONE.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, sample_en, done, busy and bit_vld are 0, and trial and result are all zeros.
- R2: A start accepted at a clock edge causes sample_en to be 1 for exactly the 6 cycles that follow that edge. During those cycles trial is 0, result is 0 and busy is 1.
- R3: The 10 cycles after sampling are the conversion cycles, with busy 1. In the first of them, trial has only bit 9 set (value 512).
- R4: In each conversion cycle, trial holds the already decided upper bits, then a 1 in the bit under test, then zeros in every lower bit. The bit under test moves from bit 9 down to bit 0, one bit per cycle.
- R5: At the end of each conversion cycle the tested bit is stored as 0 if cmp_hi is 1, and as 1 if cmp_hi is 0. With an ideal comparator (cmp_hi = trial > input), the final result equals the input code.
- R6: done is 1 for exactly one cycle, 16 cycles after the start edge (the cycle after the bit 0 decision). busy is 0 in that cycle.
- R7: result is cleared when a start is accepted. After done, result keeps the final code until the next accepted start, whatever cmp_hi does.
- R8: A start that arrives during sampling or conversion is ignored: the running sequence and its result are unchanged.
- R9: In the cycle after each decision, bit_vld is 1 and bit_out carries the decided bit, most significant bit first. In all other cycles bit_vld is 0.
- R10: A start that arrives in the done cycle is accepted. The next cycle begins a new sampling window with result cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle conversion request |
| cmp_hi | input | 1 | Comparator: 1 = summing node above trip point (clear bit) |
| sample_en | output | 1 | Closes the sample switches |
| trial | output | 10 | Trial code driven to the switch array |
| result | output | 10 | Decided code; final and held after done |
| bit_out | output | 1 | Most recently decided bit |
| bit_vld | output | 1 | bit_out is valid this cycle |
| busy | output | 1 | Sampling or converting |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one conversion and the acceptance of the next start. The bench raises start exactly in the done cycle. It then checks three things. The old code is still visible while done is high. The following cycle opens a fresh sampling window with result cleared and done low. The second conversion then produces its own input code. Starts raised in the middle of sampling and in the middle of the search are judged the same way: the full per-cycle trial, stream and done timing must match an undisturbed run.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2,
        ST_DONE    = 2'd3
    } sar_state_e;
endpackage

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
#(
    parameter int WIDTH         = 10,
    parameter int SAMPLE_CYCLES = 6,
    localparam int MAXC  = (SAMPLE_CYCLES > WIDTH) ? SAMPLE_CYCLES : WIDTH,
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             accept,
    output logic             sample_en,
    output logic             convert_en,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] bit_idx
);
    sar_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] MSB_IDX     = CNT_W'(WIDTH - 1);

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d = ST_SAMPLE;
                    cnt_d   = '0;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_SAMPLE: begin
                if (cnt_q == SAMPLE_LAST) begin
                    state_d = ST_CONVERT;
                    cnt_d   = MSB_IDX;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_CONVERT: begin
                if (cnt_q == '0) begin
                    state_d = ST_DONE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output process
    always_comb begin
        sample_en  = 1'b0;
        convert_en = 1'b0;
        done       = 1'b0;
        accept     = 1'b0;
        unique case (state_q)
            ST_IDLE:    accept     = start;
            ST_SAMPLE:  sample_en  = 1'b1;
            ST_CONVERT: convert_en = 1'b1;
            ST_DONE: begin
                done   = 1'b1;
                accept = start;
            end
            default: ;
        endcase
        busy    = sample_en | convert_en;
        bit_idx = cnt_q;
    end

    // R6
    // done lasts one cycle
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    // the last decision step is followed by the done cycle
    done_after_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (convert_en && bit_idx == '0) |=> done);

    // R8
    // a start during the search never reopens sampling
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (convert_en && start) |=> !sample_en);

    // R10
    // a start in the done cycle opens a new sampling window
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (sample_en && bit_idx == '0));
endmodule

// File: rtl/sar_bits.sv
module sar_bits #(
    parameter int WIDTH = 10,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic             sample_en,
    input  logic             convert_en,
    input  logic [CNT_W-1:0] bit_idx,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] result,
    output logic             bit_out,
    output logic             bit_vld
);
    logic keep_bit;
    assign keep_bit = ~cmp_hi;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic under_test;
        assign under_test = convert_en && (bit_idx == CNT_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                result[i] <= 1'b0;
            end else if (accept) begin
                result[i] <= 1'b0;
            end else if (under_test) begin
                result[i] <= keep_bit;
            end
        end

        assign trial[i] = result[i] | under_test;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_out <= 1'b0;
            bit_vld <= 1'b0;
        end else begin
            bit_vld <= convert_en;
            if (convert_en) begin
                bit_out <= keep_bit;
            end
        end
    end

    // R2
    // nothing is driven to the array while sampling
    sample_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> (trial == '0 && result == '0));

    // R3
    // the search opens on the MSB alone
    first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convert_en) |-> (trial == (WIDTH'(1) << (WIDTH - 1))));

    // R4
    // exactly one bit separates trial from the decided bits
    trial_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        convert_en |-> ($countones(trial ^ result) == 1));

    // R7
    // result holds while no start is accepted outside the search
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!convert_en && !accept) |=> $stable(result));

    // R9
    // the streamed bit agrees with the stored decision
    stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (convert_en && !cmp_hi) |=> (bit_vld && bit_out));
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
    parameter int WIDTH         = 10,
    parameter int SAMPLE_CYCLES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_hi,
    output logic             sample_en,
    output logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] result,
    output logic             bit_out,
    output logic             bit_vld,
    output logic             busy,
    output logic             done
);
    localparam int MAXC  = (SAMPLE_CYCLES > WIDTH) ? SAMPLE_CYCLES : WIDTH;
    localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;

    logic             accept;
    logic             convert_en;
    logic [CNT_W-1:0] bit_idx;

    sar_fsm #(
        .WIDTH         (WIDTH),
        .SAMPLE_CYCLES (SAMPLE_CYCLES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .accept     (accept),
        .sample_en  (sample_en),
        .convert_en (convert_en),
        .busy       (busy),
        .done       (done),
        .bit_idx    (bit_idx)
    );

    sar_bits #(
        .WIDTH (WIDTH),
        .CNT_W (CNT_W)
    ) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .sample_en  (sample_en),
        .convert_en (convert_en),
        .bit_idx    (bit_idx),
        .cmp_hi     (cmp_hi),
        .trial      (trial),
        .result     (result),
        .bit_out    (bit_out),
        .bit_vld    (bit_vld)
    );

    // R1
    // idle outputs are quiet
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (trial == result));
endmodule

// File: tb/sar_ctrl_bench.sv
module sar_ctrl_bench;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_hi;
    logic         sample_en, bit_out, bit_vld, busy, done;
    logic [W-1:0] trial, result;
    logic [W-1:0] vin = '0;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // ideal comparator: node above trip when trial exceeds input
    assign cmp_hi = (trial > vin);

    sar_ctrl u_sar_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmp_hi    (cmp_hi),
        .sample_en (sample_en),
        .trial     (trial),
        .result    (result),
        .bit_out   (bit_out),
        .bit_vld   (bit_vld),
        .busy      (busy),
        .done      (done)
    );

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic test_reset();
        // R1
        check(sample_en == 0 && done == 0 && busy == 0 && bit_vld == 0, "R1 ctrl", {sample_en, done, busy, bit_vld}, 0);
        check(trial == 0 && result == 0, "R1 data", trial | result, 0);
    endtask

    // One conversion with cycle-by-cycle checks. Cycle c=0 is the cycle after
    // the accepting edge. poke = cycle in which an extra start is raised.
    task automatic conv(int v, int poke, bit launched);
        logic [W-1:0] code;
        code = W'(v);
        vin  = code;
        if (!launched) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c <= 16; c++) begin
            if (c < 6) begin
                // R2
                check(sample_en == 1 && busy == 1, "R2 sample", sample_en, 1);
                check(trial == 0 && result == 0, "R2 idle data", trial, 0);
            end else if (c < 16) begin
                int idx;
                logic [W-1:0] upper, exp_t;
                idx   = 15 - c;
                upper = code & ~((W'(1) << (idx + 1)) - W'(1));
                exp_t = upper | (W'(1) << idx);
                check(sample_en == 0 && busy == 1, "R3 convert", busy, 1);
                // R4
                check(trial == exp_t, "R4 trial", trial, exp_t);
                // R5 partial result
                check(result == upper, "R5 partial", result, upper);
            end else begin
                // R6
                check(done == 1 && busy == 0, "R6 done", done, 1);
                // R5
                check(result == code, "R5 final", result, code);
            end
            if (c != 16) check(done == 0, "R6 no early done", done, 0);
            if (c >= 7) begin
                // R9
                check(bit_vld == 1 && bit_out == code[16 - c], "R9 stream",
                      {bit_vld, bit_out}, {1'b1, code[16 - c]});
            end else begin
                check(bit_vld == 0, "R9 quiet", bit_vld, 0);
            end
            start = (c == poke);
            if (c < 16) @(negedge clk);
        end
    endtask

    task automatic test_hold(int v);
        logic [W-1:0] code;
        code = W'(v);
        conv(v, -1, 0);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 8; k++) begin
            vin = W'(k * 97);
            // R7
            check(result == code && done == 0 && busy == 0 && sample_en == 0,
                  "R7 hold", result, code);
            @(negedge clk);
        end
    endtask

    task automatic test_ignore();
        // R8: starts raised mid-sampling and mid-search
        conv(341, 3, 0);
        @(negedge clk);
        check(busy == 0 && result == W'(341), "R8 after", result, 341);
        conv(682, 11, 0);
        @(negedge clk);
        check(busy == 0 && result == W'(682), "R8 after search poke", result, 682);
    endtask

    task automatic test_back_to_back();
        // R10: start in the done cycle
        conv(600, 16, 0);
        conv(77, -1, 1);
        @(negedge clk);
        check(result == W'(77) && busy == 0, "R10 second code", result, 77);
    endtask

    initial begin
        #1;
        test_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        conv(0, -1, 0);
        @(negedge clk);
        conv(1023, -1, 0);
        @(negedge clk);
        conv(512, -1, 0);
        @(negedge clk);
        conv(511, -1, 0);
        @(negedge clk);
        test_hold(200);
        test_ignore();
        test_back_to_back();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule